// File: doc/BRIEF.md
# Programmable Majority Pattern Decision

This block decides, once per clock, whether one stored pattern of an associative pattern bank counts as matched. Its input is a map with one bit per detector layer, each bit high when that layer of the pattern fired. Global configuration sets how many layers may be missing (none, one or two), or turns matching off. A second global option requires that layer 0 be among the fired layers.

Each pattern also holds a private disable bit. Production test writes it through a word-line with separate set and clear strobes, so that a defective pattern can be silenced and the rest of the chip kept in use. Two global read controls sit above the count decision. Force-read makes the pattern report a match whatever its count. Block-read suppresses every match.

The decision is registered into a match flag. A read flag goes up with it and stays up until the readout logic acknowledges the pattern.

Top module: `patt_majority`

## Requirements
- R1: A high `init` at a rising clock edge clears `match_q` and `rd_flag` at that edge.
- R2: The miss-select lines set the minimum number of high bits in `layer_hits`. `miss0_sel` alone requires all 8 bits. `miss1_sel` alone requires at least 7 bits. `miss2_sel` alone requires at least 6 bits.
- R3: When several miss-select lines are high, the one allowing the most misses applies. When none is high, the count decision never gives a match.
- R4: While `need_layer0` is high, a match from the count decision also requires `layer_hits[0]` to be high.
- R5: `force_rd` high gives a match whatever the layer count, miss selection and `need_layer0`. It does not override R6 or R7.
- R6: `block_rd` high gives no match, whatever the other inputs.
- R7: The disable bit is set by `wl` and `dis_set` high together, and cleared by `wl` and `dis_clr` high together. When both strobes are high with `wl`, set wins. With `wl` low the strobes have no effect. While the bit is set, `match_q` stays low, even with `force_rd` high.
- R8: `init` does not change the disable bit.
- R9: The inputs present in a cycle decide `match_q` at the next rising edge. `match_q` keeps that value for one cycle.
- R10: `rd_flag` rises at the same edge as `match_q`. It then holds until an edge with `rd_ack` high and no new match. A match at the same edge as `rd_ack` keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init | input | 1 | Synchronous active-high reset of the match and read flags |
| layer_hits | input | NL (8) | Fired-layer map of this pattern, bit 0 = layer 0 |
| miss0_sel | input | 1 | Global: allow no missing layer |
| miss1_sel | input | 1 | Global: allow one missing layer |
| miss2_sel | input | 1 | Global: allow two missing layers |
| need_layer0 | input | 1 | Global: layer 0 must have fired |
| force_rd | input | 1 | Global: report a match regardless of the count |
| block_rd | input | 1 | Global: suppress any match |
| wl | input | 1 | Word-line selecting this pattern's disable bit for writing |
| dis_set | input | 1 | Set strobe for the disable bit |
| dis_clr | input | 1 | Clear strobe for the disable bit |
| rd_ack | input | 1 | Readout acknowledge, clears `rd_flag` |
| match_q | output | 1 | Registered pattern-match flag |
| rd_flag | output | 1 | Pending-read flag for downstream readout |

## Verification
Two functions can fall in the same cycle: a readout acknowledge, which clears the read flag, and a fresh match, which sets it. The bench holds a pending read flag, then drives `rd_ack` in the same cycle as a full eight-layer match. It expects `rd_flag` still high after the edge. A later acknowledge with no match must bring the flag down. The same edge-sharing is checked for the disable-bit strobes: set and clear are driven with the word-line in one cycle, and a forced read must then stay unmatched.

// File: rtl/patt_majority_pkg.sv
package patt_majority_pkg;

  // Threshold mode chosen from the three miss-select lines
  typedef enum logic [1:0] {
    THR_OFF   = 2'd0,
    THR_MISS0 = 2'd1,
    THR_MISS1 = 2'd2,
    THR_MISS2 = 2'd3
  } thr_mode_e;

  // The most permissive selection wins; nothing selected means off
  function automatic thr_mode_e pick_mode(input logic m0, input logic m1, input logic m2);
    thr_mode_e r;
    if (m2)      r = THR_MISS2;
    else if (m1) r = THR_MISS1;
    else if (m0) r = THR_MISS0;
    else         r = THR_OFF;
    return r;
  endfunction

  // Number of misses a mode tolerates
  function automatic int allowed_miss(input thr_mode_e md);
    int r;
    case (md)
      THR_MISS0: r = 0;
      THR_MISS1: r = 1;
      THR_MISS2: r = 2;
      default:   r = -1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/patt_thr_eval.sv
module patt_thr_eval
  import patt_majority_pkg::*;
#(
  parameter int NL = 8
) (
  input  logic [NL-1:0] hits,
  input  thr_mode_e     mode,
  input  logic          need_l0,
  output logic          pass
);
  localparam int CNT_W = $clog2(NL + 1);

  logic [CNT_W-1:0] cnt;
  int               miss_ok;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NL; i++) begin
      cnt = cnt + CNT_W'(hits[i]);
    end
  end

  always_comb begin
    miss_ok = allowed_miss(mode);
    if (miss_ok < 0) begin
      pass = 1'b0;
    end else begin
      pass = (int'(cnt) >= (NL - miss_ok)) && (!need_l0 || hits[0]);
    end
  end

endmodule

// File: rtl/patt_dis_bit.sv
module patt_dis_bit (
  input  logic clk,
  input  logic wl,
  input  logic set_i,
  input  logic clr_i,
  output logic dis_q
);
  // Storage bit with no reset: it keeps its value through init
  always_ff @(posedge clk) begin
    if (wl && set_i)      dis_q <= 1'b1;
    else if (wl && clr_i) dis_q <= 1'b0;
  end

endmodule

// File: rtl/patt_majority.sv
module patt_majority
  import patt_majority_pkg::*;
#(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          init,
  input  logic [NL-1:0] layer_hits,
  input  logic          miss0_sel,
  input  logic          miss1_sel,
  input  logic          miss2_sel,
  input  logic          need_layer0,
  input  logic          force_rd,
  input  logic          block_rd,
  input  logic          wl,
  input  logic          dis_set,
  input  logic          dis_clr,
  input  logic          rd_ack,
  output logic          match_q,
  output logic          rd_flag
);
  thr_mode_e mode;
  logic      cnt_pass;
  logic      dis_q;
  logic      match_d;

  assign mode = pick_mode(miss0_sel, miss1_sel, miss2_sel);

  patt_thr_eval #(.NL(NL)) thr_i (
    .hits    (layer_hits),
    .mode    (mode),
    .need_l0 (need_layer0),
    .pass    (cnt_pass)
  );

  patt_dis_bit dis_i (
    .clk   (clk),
    .wl    (wl),
    .set_i (dis_set),
    .clr_i (dis_clr),
    .dis_q (dis_q)
  );

  // Priority: block-read, then pattern disable, then force, then count
  always_comb begin
    if (block_rd)      match_d = 1'b0;
    else if (dis_q)    match_d = 1'b0;
    else if (force_rd) match_d = 1'b1;
    else               match_d = cnt_pass;
  end

  always_ff @(posedge clk) begin
    if (init) begin
      match_q <= 1'b0;
      rd_flag <= 1'b0;
    end else begin
      match_q <= match_d;
      if (match_d)     rd_flag <= 1'b1;
      else if (rd_ack) rd_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/patt_majority_chk.sv
module patt_majority_chk #(
  parameter int NL = 8
) (
  input logic          clk,
  input logic          init,
  input logic [NL-1:0] layer_hits,
  input logic          miss0_sel,
  input logic          miss1_sel,
  input logic          miss2_sel,
  input logic          need_layer0,
  input logic          force_rd,
  input logic          block_rd,
  input logic          wl,
  input logic          dis_set,
  input logic          dis_q,
  input logic          rd_ack,
  input logic          match_q,
  input logic          rd_flag
);
  // R1
  init_clears_chk: assert property (@(posedge clk) init |=> (!match_q && !rd_flag));

  // R2
  below_floor_chk: assert property (@(posedge clk) disable iff (init)
    (!force_rd && ($countones(layer_hits) < NL - 2)) |=> !match_q);

  // R3
  mode_off_chk: assert property (@(posedge clk) disable iff (init)
    (!force_rd && !miss0_sel && !miss1_sel && !miss2_sel) |=> !match_q);

  // R4
  layer0_need_chk: assert property (@(posedge clk) disable iff (init)
    (!force_rd && need_layer0 && !layer_hits[0]) |=> !match_q);

  // R5
  force_match_chk: assert property (@(posedge clk) disable iff (init)
    (force_rd && !block_rd && !dis_q) |=> match_q);

  // R6
  block_read_chk: assert property (@(posedge clk) disable iff (init)
    block_rd |=> !match_q);

  // R7
  dis_set_chk: assert property (@(posedge clk) disable iff (init)
    (wl && dis_set) |-> ##2 !match_q);

  // R10
  flag_follows_chk: assert property (@(posedge clk) disable iff (init)
    match_q |-> rd_flag);

  // R10
  flag_drop_chk: assert property (@(posedge clk) disable iff (init)
    ($fell(rd_flag) && !$past(init)) |-> $past(rd_ack));

endmodule

bind patt_majority patt_majority_chk #(.NL(NL)) chk_i (
  .clk         (clk),
  .init        (init),
  .layer_hits  (layer_hits),
  .miss0_sel   (miss0_sel),
  .miss1_sel   (miss1_sel),
  .miss2_sel   (miss2_sel),
  .need_layer0 (need_layer0),
  .force_rd    (force_rd),
  .block_rd    (block_rd),
  .wl          (wl),
  .dis_set     (dis_set),
  .dis_q       (dis_q),
  .rd_ack      (rd_ack),
  .match_q     (match_q),
  .rd_flag     (rd_flag)
);

// File: tb/patt_majority_tb_top.sv
module patt_majority_tb_top;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          init;
  logic [NL-1:0] layer_hits;
  logic          miss0_sel, miss1_sel, miss2_sel;
  logic          need_layer0, force_rd, block_rd;
  logic          wl, dis_set, dis_clr, rd_ack;
  logic          match_q, rd_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  patt_majority #(.NL(NL)) dut_i (
    .clk(clk), .init(init), .layer_hits(layer_hits),
    .miss0_sel(miss0_sel), .miss1_sel(miss1_sel), .miss2_sel(miss2_sel),
    .need_layer0(need_layer0), .force_rd(force_rd), .block_rd(block_rd),
    .wl(wl), .dis_set(dis_set), .dis_clr(dis_clr), .rd_ack(rd_ack),
    .match_q(match_q), .rd_flag(rd_flag)
  );

  // Vector: [14:7] hits, [6] miss0, [5] miss1, [4] miss2,
  //         [3] need_layer0, [2] force, [1] block, [0] expected match
  localparam logic [14:0] VEC [16] = '{
    {8'hFF, 3'b100, 3'b000, 1'b1},  // R2 all eight, zero-miss
    {8'hFE, 3'b100, 3'b000, 1'b0},  // R2 seven, zero-miss
    {8'hFE, 3'b010, 3'b000, 1'b1},  // R2 seven, one-miss
    {8'h7E, 3'b010, 3'b000, 1'b0},  // R2 six, one-miss
    {8'h7E, 3'b001, 3'b000, 1'b1},  // R2 six, two-miss
    {8'h3E, 3'b001, 3'b000, 1'b0},  // R2 five, two-miss
    {8'hFF, 3'b000, 3'b000, 1'b0},  // R3 none selected
    {8'hFE, 3'b110, 3'b000, 1'b1},  // R3 one-miss beats zero-miss
    {8'h7E, 3'b111, 3'b000, 1'b1},  // R3 two-miss beats all
    {8'hFE, 3'b010, 3'b100, 1'b0},  // R4 layer 0 missing
    {8'hFD, 3'b010, 3'b100, 1'b1},  // R4 layer 0 present
    {8'h00, 3'b000, 3'b010, 1'b1},  // R5 force, nothing fired
    {8'h00, 3'b000, 3'b110, 1'b1},  // R5 force beats layer 0 need
    {8'hFF, 3'b100, 3'b011, 1'b0},  // R6 block beats force
    {8'hFF, 3'b100, 3'b001, 1'b0},  // R6 block beats count
    {8'h7F, 3'b001, 3'b100, 1'b1}   // R4 seven incl. layer 0, two-miss
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    layer_hits = '0; miss0_sel = 0; miss1_sel = 0; miss2_sel = 0;
    need_layer0 = 0; force_rd = 0; block_rd = 0;
    wl = 0; dis_set = 0; dis_clr = 0;
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    quiet(); rd_ack = 0; init = 1;
    wl = 1; dis_clr = 1;
    cyc(); cyc();
    wl = 0; dis_clr = 0;
    chk("R1 reset match", match_q, 1'b0);
    chk("R1 reset rd_flag", rd_flag, 1'b0);
    init = 0;

    // Table walk with acknowledge held, so rd_flag tracks match_q
    rd_ack = 1;
    for (int i = 0; i < 16; i++) begin
      layer_hits = VEC[i][14:7];
      miss0_sel = VEC[i][6]; miss1_sel = VEC[i][5]; miss2_sel = VEC[i][4];
      need_layer0 = VEC[i][3]; force_rd = VEC[i][2]; block_rd = VEC[i][1];
      cyc();
      chk($sformatf("R2-table vector %0d match", i), match_q, VEC[i][0]);
      chk($sformatf("R10 table vector %0d rd_flag", i), rd_flag, VEC[i][0]);
    end
    quiet(); rd_ack = 1; cyc();

    // R1: init clears a set match and flag
    force_rd = 1; cyc();
    chk("R1 pre-init match", match_q, 1'b1);
    init = 1; cyc();
    chk("R1 init match", match_q, 1'b0);
    chk("R1 init rd_flag", rd_flag, 1'b0);
    init = 0; quiet(); cyc();

    // R9: one cycle latency, one cycle duration
    layer_hits = 8'hFF; miss0_sel = 1;
    #1 chk("R9 before edge", match_q, 1'b0);
    cyc();
    quiet();
    chk("R9 after edge", match_q, 1'b1);
    cyc();
    chk("R9 one cycle only", match_q, 1'b0);

    // R7: strobes without word-line do nothing
    dis_set = 1; cyc(); dis_set = 0;
    force_rd = 1; cyc();
    chk("R7 no wl no effect", match_q, 1'b1);
    // R7: set via word-line blocks even force
    force_rd = 0; wl = 1; dis_set = 1; cyc(); wl = 0; dis_set = 0;
    force_rd = 1; layer_hits = 8'hFF; miss0_sel = 1; cyc();
    chk("R7 disabled blocks force", match_q, 1'b0);
    // R8: init keeps the bit
    init = 1; cyc(); init = 0; cyc();
    chk("R8 bit survives init", match_q, 1'b0);
    // R7: clear via word-line
    wl = 1; dis_clr = 1; cyc(); wl = 0; dis_clr = 0; cyc();
    chk("R7 cleared", match_q, 1'b1);
    // R7: set and clear together, set wins
    wl = 1; dis_set = 1; dis_clr = 1; cyc(); wl = 0; dis_set = 0; dis_clr = 0; cyc();
    chk("R7 set wins", match_q, 1'b0);
    wl = 1; dis_clr = 1; cyc(); quiet(); cyc();

    // R10: flag holds until acknowledge
    rd_ack = 0;
    layer_hits = 8'hFF; miss0_sel = 1; cyc(); quiet();
    chk("R10 rises with match", rd_flag, 1'b1);
    cyc(); cyc(); cyc();
    chk("R10 holds", rd_flag, 1'b1);
    chk("R10 match gone", match_q, 1'b0);
    // ack and new match in the same cycle
    rd_ack = 1; layer_hits = 8'hFF; miss0_sel = 1; cyc(); quiet();
    chk("R10 match beats ack", rd_flag, 1'b1);
    cyc();
    chk("R10 ack clears", rd_flag, 1'b0);
    rd_ack = 0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule